// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Cluster

This block gives every core in a small shared-bus multiprocessor its own direct-mapped, write-back data cache. Each line is invalid, shared or modified. Coherence comes from snooping: every controller watches each transaction that another controller places on the shared bus. When another core reads a line that this controller holds dirty, this controller supplies that line. When another core claims a line for writing, this controller drops its own copy. At any moment there is at most one writer, and there may be many readers.

Inside the block are one controller per core, a fixed-priority bus arbiter and a word-wide memory model. The bus completes one transaction per granted cycle. A core holds its request steady until a one-cycle completion pulse. Loads and stores that hit are answered one cycle after the request and use no bus cycle. Misses, upgrades and write-backs each take one granted bus cycle.

Top module: `snp_coherent_cluster`

## Requirements
- R1: After reset every line in every cache is invalid, no completion pulse is high and the bus is idle.
- R2: A load miss issues a bus read (command code 0) for the requested address. The line is loaded as shared, and the core receives the current value of that address.
- R3: A load that hits a shared or modified line completes one cycle after the request and causes no bus transaction.
- R4: A store to a shared line first issues an invalidate (command code 2). A store to an absent line issues a read-for-ownership (command code 1). In both cases the line then becomes modified and holds the stored value.
- R5: A store to a line that is already modified causes no bus transaction.
- R6: A read-for-ownership or invalidate from another core drops the local copy of that address, so the next local access to it misses.
- R7: When a snooped bus read hits a modified line, the owning cache supplies the data instead of memory. Memory is updated in the same transaction, and the owner's line becomes shared, so a later store by the owner needs a new invalidate.
- R8: Replacing a modified line first issues a write-back (command code 3) of the old address, then the fill. The written-back value is what memory later returns.
- R9: When several controllers request the bus in the same cycle, the lowest-numbered core is granted first, and only one controller is granted per cycle.
- R10: Each access ends with a single-cycle completion pulse, and the core waits until that pulse.
- R11: Writes to one address are serialized on the bus, so after any sequence of accesses every core reads the same, most recently written value for every address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_req_i | input | N_CORES | Access request per core, held until completion |
| core_we_i | input | N_CORES | 1 for store, 0 for load, per core |
| core_addr_i | input | N_CORES*AW | Word address per core |
| core_wdata_i | input | N_CORES*DW | Store data per core |
| core_rdata_o | output | N_CORES*DW | Load result per core, valid with completion |
| core_done_o | output | N_CORES | One-cycle completion pulse per core |
| bus_valid_o | output | 1 | A bus transaction occupies this cycle |
| bus_cmd_o | output | 2 | Command of the current transaction: 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_addr_o | output | AW | Address of the current transaction |

## Verification
A line state that diverges between caches shows up as a stale load value, usually at the next load of that address by the other core, two cycles after its request. A line wrongly left valid also hides a bus transaction that should have appeared. A missed downgrade or a lost dirty flag shows up one access later: a store goes out with no invalidate, or an eviction goes out with no write-back. The bench therefore checks both the returned values and the exact command and address sequence on the bus for each access.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_MOD = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_RD  = 2'b00,
    BUS_RDX = 2'b01,
    BUS_UPG = 2'b10,
    BUS_WB  = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_WB,
    CT_MISS,
    CT_UPG
  } ctl_st_e;
endpackage

// File: rtl/snp_arbiter.sv
module snp_arbiter #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)) else $error("grant not onehot"); // R9
  AST_GNT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0) else $error("grant without request"); // R9
  AST_GNT_PRIO0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> gnt_o[0]) else $error("priority violated"); // R9
endmodule

// File: rtl/snp_memory.sv
module snp_memory #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(i * 7 + 3);
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/snp_cache_ctl.sv
module snp_cache_ctl
  import snp_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int LINES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          core_req_i,
  input  logic          core_we_i,
  input  logic [AW-1:0] core_addr_i,
  input  logic [DW-1:0] core_wdata_i,
  output logic [DW-1:0] core_rdata_o,
  output logic          core_done_o,
  output logic          bus_req_o,
  output bus_cmd_e      bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_gnt_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          snp_valid_i,
  input  bus_cmd_e      snp_cmd_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic          snp_flush_o,
  output logic [DW-1:0] snp_data_o
);
  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - IDXW;

  line_st_e        st_q   [LINES];
  logic [TAGW-1:0] tag_q  [LINES];
  logic [DW-1:0]   data_q [LINES];
  ctl_st_e         state_q;
  logic            done_q;
  logic [DW-1:0]   rdata_q;

  logic [IDXW-1:0] req_idx, snp_idx;
  logic [TAGW-1:0] req_tag, snp_tag;
  logic            hit, snp_hit, snp_near, accept;

  assign req_idx = core_addr_i[IDXW-1:0];
  assign req_tag = core_addr_i[AW-1:IDXW];
  assign snp_idx = snp_addr_i[IDXW-1:0];
  assign snp_tag = snp_addr_i[AW-1:IDXW];

  assign hit      = (st_q[req_idx] != LN_INV) && (tag_q[req_idx] == req_tag);
  assign snp_hit  = snp_valid_i && (st_q[snp_idx] != LN_INV) && (tag_q[snp_idx] == snp_tag);
  assign snp_near = snp_valid_i && (snp_idx == req_idx);
  // snoop traffic on the same set wins over a local access this cycle
  assign accept   = (state_q == CT_IDLE) && core_req_i && !done_q && !snp_near;

  assign snp_flush_o = snp_hit && (st_q[snp_idx] == LN_MOD) &&
                       ((snp_cmd_i == BUS_RD) || (snp_cmd_i == BUS_RDX));
  assign snp_data_o  = data_q[snp_idx];

  assign bus_req_o   = (state_q != CT_IDLE);
  assign bus_wdata_o = data_q[req_idx];
  always_comb begin
    bus_addr_o = core_addr_i;
    unique case (state_q)
      CT_WB: begin
        bus_cmd_o  = BUS_WB;
        bus_addr_o = {tag_q[req_idx], req_idx};
      end
      CT_UPG:  bus_cmd_o = BUS_UPG;
      CT_MISS: bus_cmd_o = core_we_i ? BUS_RDX : BUS_RD;
      default: bus_cmd_o = BUS_RD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= LN_INV;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
      state_q <= CT_IDLE;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (snp_hit) begin
        if (snp_cmd_i == BUS_RD) begin
          if (st_q[snp_idx] == LN_MOD) st_q[snp_idx] <= LN_SHR;
        end else if (snp_cmd_i != BUS_WB) begin
          st_q[snp_idx] <= LN_INV;
        end
      end
      unique case (state_q)
        CT_IDLE: if (accept) begin
          if (hit && !core_we_i) begin
            rdata_q <= data_q[req_idx];
            done_q  <= 1'b1;
          end else if (hit && st_q[req_idx] == LN_MOD) begin
            data_q[req_idx] <= core_wdata_i;
            done_q          <= 1'b1;
          end else if (hit) begin
            state_q <= CT_UPG;
          end else if (st_q[req_idx] == LN_MOD) begin
            state_q <= CT_WB;
          end else begin
            state_q <= CT_MISS;
          end
        end
        CT_WB: begin
          if (bus_gnt_i) begin
            st_q[req_idx] <= LN_INV;
            state_q       <= CT_MISS;
          end else if (snp_near) begin
            state_q <= CT_IDLE;  // victim may have changed; re-evaluate
          end
        end
        CT_UPG: begin
          if (bus_gnt_i) begin
            st_q[req_idx]   <= LN_MOD;
            data_q[req_idx] <= core_wdata_i;
            done_q          <= 1'b1;
            state_q         <= CT_IDLE;
          end else if (snp_near) begin
            state_q <= CT_IDLE;
          end
        end
        CT_MISS: begin
          if (bus_gnt_i) begin
            tag_q[req_idx] <= req_tag;
            if (core_we_i) begin
              data_q[req_idx] <= core_wdata_i;
              st_q[req_idx]   <= LN_MOD;
            end else begin
              data_q[req_idx] <= bus_rdata_i;
              rdata_q         <= bus_rdata_i;
              st_q[req_idx]   <= LN_SHR;
            end
            done_q  <= 1'b1;
            state_q <= CT_IDLE;
          end
        end
        default: state_q <= CT_IDLE;
      endcase
    end
  end

  assign core_done_o  = done_q;
  assign core_rdata_o = rdata_q;

  AST_SNP_INVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_hit && (snp_cmd_i == BUS_RDX || snp_cmd_i == BUS_UPG))
      |=> st_q[$past(snp_idx)] == LN_INV) else $error("copy kept after remote claim"); // R6
  AST_SNP_DOWNGRADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_flush_o && snp_cmd_i == BUS_RD)
      |=> st_q[$past(snp_idx)] == LN_SHR) else $error("owner not downgraded"); // R7
  AST_OWN_AFTER_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && (bus_cmd_o == BUS_RDX || bus_cmd_o == BUS_UPG))
      |=> st_q[$past(req_idx)] == LN_MOD) else $error("claim did not yield modified"); // R4
  AST_STORE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && core_we_i && hit && st_q[req_idx] == LN_MOD)
      |=> !bus_req_o) else $error("bus used for modified store"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_done_o |=> !core_done_o) else $error("done longer than a cycle"); // R10
endmodule

// File: rtl/snp_coherent_cluster.sv
module snp_coherent_cluster
  import snp_pkg::*;
#(
  parameter int N_CORES = 2,
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int LINES   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CORES-1:0]    core_req_i,
  input  logic [N_CORES-1:0]    core_we_i,
  input  logic [N_CORES*AW-1:0] core_addr_i,
  input  logic [N_CORES*DW-1:0] core_wdata_i,
  output logic [N_CORES*DW-1:0] core_rdata_o,
  output logic [N_CORES-1:0]    core_done_o,
  output logic                  bus_valid_o,
  output logic [1:0]            bus_cmd_o,
  output logic [AW-1:0]         bus_addr_o
);
  logic [N_CORES-1:0] req, gnt, flush;
  bus_cmd_e           c_cmd   [N_CORES];
  logic [AW-1:0]      c_addr  [N_CORES];
  logic [DW-1:0]      c_wdata [N_CORES];
  logic [DW-1:0]      c_fdata [N_CORES];

  bus_cmd_e      bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, flush_data, mem_rdata, bus_rdata;
  logic          bus_valid, flush_any, mem_we;
  logic [DW-1:0] mem_wdata;

  snp_arbiter #(.N(N_CORES)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .gnt_o (gnt)
  );

  always_comb begin
    bus_cmd   = BUS_RD;
    bus_addr  = '0;
    bus_wdata = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (gnt[i]) begin
        bus_cmd   = c_cmd[i];
        bus_addr  = c_addr[i];
        bus_wdata = c_wdata[i];
      end
    end
  end

  always_comb begin
    flush_data = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (flush[i]) flush_data = flush_data | c_fdata[i];
    end
  end

  assign bus_valid = |gnt;
  assign flush_any = |flush;
  assign bus_rdata = flush_any ? flush_data : mem_rdata;
  assign mem_we    = (bus_valid && bus_cmd == BUS_WB) || flush_any;
  assign mem_wdata = flush_any ? flush_data : bus_wdata;

  snp_memory #(.AW(AW), .DW(DW)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (mem_we),
    .wr_addr_i(bus_addr),
    .wr_data_i(mem_wdata),
    .rd_addr_i(bus_addr),
    .rd_data_o(mem_rdata)
  );

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    snp_cache_ctl #(.AW(AW), .DW(DW), .LINES(LINES)) u_ctl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .core_req_i  (core_req_i[g]),
      .core_we_i   (core_we_i[g]),
      .core_addr_i (core_addr_i[g*AW +: AW]),
      .core_wdata_i(core_wdata_i[g*DW +: DW]),
      .core_rdata_o(core_rdata_o[g*DW +: DW]),
      .core_done_o (core_done_o[g]),
      .bus_req_o   (req[g]),
      .bus_cmd_o   (c_cmd[g]),
      .bus_addr_o  (c_addr[g]),
      .bus_wdata_o (c_wdata[g]),
      .bus_gnt_i   (gnt[g]),
      .bus_rdata_i (bus_rdata),
      .snp_valid_i (bus_valid && !gnt[g]),
      .snp_cmd_i   (bus_cmd),
      .snp_addr_i  (bus_addr),
      .snp_flush_o (flush[g]),
      .snp_data_o  (c_fdata[g])
    );
  end

  assign bus_valid_o = bus_valid;
  assign bus_cmd_o   = bus_cmd;
  assign bus_addr_o  = bus_addr;

  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flush) <= 1) else $error("two owners flushed"); // R7
  AST_FLUSH_ON_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_any |-> bus_valid && (bus_cmd == BUS_RD || bus_cmd == BUS_RDX)) else $error("flush without read"); // R7
  AST_WB_UNSHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid && bus_cmd == BUS_WB) |-> !flush_any) else $error("write-back while another owns"); // R8
endmodule

// File: tb/sim_snp_coherent_cluster.sv
`timescale 1ns/1ps
module sim_snp_coherent_cluster;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req = '0, we = '0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  done;
  logic        bus_valid;
  logic [1:0]  bus_cmd;
  logic [3:0]  bus_addr;

  int tests = 0, fails = 0;
  int nlog;
  int log_cmd [8];
  int log_addr [8];
  logic [7:0] model [16];

  always #2.5 clk = ~clk;

  snp_coherent_cluster u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .core_req_i(req), .core_we_i(we), .core_addr_i(addr), .core_wdata_i(wdata),
    .core_rdata_o(rdata), .core_done_o(done),
    .bus_valid_o(bus_valid), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr)
  );

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic op(int c, bit w, int a, logic [7:0] d, output logic [7:0] rd, output int cyc);
    @(negedge clk);
    req[c] = 1'b1; we[c] = w; addr[c*4 +: 4] = 4'(a); wdata[c*8 +: 8] = d;
    nlog = 0; cyc = 0;
    forever begin
      #1;
      if (bus_valid && nlog < 8) begin
        log_cmd[nlog] = int'(bus_cmd); log_addr[nlog] = int'(bus_addr); nlog++;
      end
      @(negedge clk);
      cyc++;
      if (done[c] || cyc > 40) break;
    end
    rd = rdata[c*8 +: 8];
    req[c] = 1'b0;
    if (w) model[a] = d;
  endtask

  task automatic chk_log(string r, int n, int c0, int a0, int c1, int a1);
    chk(nlog == n, r, nlog, n);
    if (n > 0 && nlog > 0) chk(log_cmd[0] == c0 && log_addr[0] == a0, r, log_cmd[0]*16 + log_addr[0], c0*16 + a0);
    if (n > 1 && nlog > 1) chk(log_cmd[1] == c1 && log_addr[1] == a1, r, log_cmd[1]*16 + log_addr[1], c1*16 + a1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int cyc;
    int first_addr;
    for (int i = 0; i < 16; i++) model[i] = init_val(i);
    repeat (3) @(negedge clk);
    chk(done == 2'b00 && !bus_valid, "R1 reset outputs", {done, bus_valid}, 0);
    rst_n = 1'b1;

    // R1/R2: cold read misses with bus read
    op(0, 0, 2, 0, rd, cyc);
    chk_log("R2 read miss bus", 1, 0, 2, 0, 0);
    chk(rd == init_val(2), "R2 read miss value", rd, init_val(2));
    chk(cyc == 2, "R1 cold line misses", cyc, 2);
    // R3: hit
    op(0, 0, 2, 0, rd, cyc);
    chk_log("R3 read hit silent", 0, 0, 0, 0, 0);
    chk(cyc == 1 && rd == init_val(2), "R3 read hit latency", cyc, 1);
    op(1, 0, 2, 0, rd, cyc);
    chk_log("R2 second reader", 1, 0, 2, 0, 0);
    // R4: store to shared -> invalidate
    op(0, 1, 2, 8'h3C, rd, cyc);
    chk_log("R4 upgrade", 1, 2, 2, 0, 0);
    // R5: store to modified silent
    op(0, 1, 2, 8'h4D, rd, cyc);
    chk_log("R5 modified store silent", 0, 0, 0, 0, 0);
    chk(cyc == 1, "R5 store hit latency", cyc, 1);
    // R6/R7: other core misses, owner supplies
    op(1, 0, 2, 0, rd, cyc);
    chk_log("R6 invalidated copy misses", 1, 0, 2, 0, 0);
    chk(rd == 8'h4D, "R7 owner supplies data", rd, 8'h4D);
    op(0, 1, 2, 8'h5E, rd, cyc);
    chk_log("R7 owner downgraded to shared", 1, 2, 2, 0, 0);
    // R4: store miss -> read-for-ownership
    op(1, 1, 3, 8'h66, rd, cyc);
    chk_log("R4 store miss rdx", 1, 1, 3, 0, 0);
    op(0, 0, 3, 0, rd, cyc);
    chk_log("R7 read of remote dirty", 1, 0, 3, 0, 0);
    chk(rd == 8'h66, "R7 remote dirty value", rd, 8'h66);
    // R8: eviction of modified line
    op(0, 1, 1, 8'h11, rd, cyc);
    chk_log("R4 store miss rdx idx1", 1, 1, 1, 0, 0);
    op(0, 0, 5, 0, rd, cyc);
    chk_log("R8 writeback then fill", 2, 3, 1, 0, 5);
    chk(rd == init_val(5), "R8 fill value", rd, init_val(5));
    op(1, 0, 1, 0, rd, cyc);
    chk_log("R8 memory read after wb", 1, 0, 1, 0, 0);
    chk(rd == 8'h11, "R8 written-back value", rd, 8'h11);

    // R9: simultaneous misses
    @(negedge clk);
    req = 2'b11; we = 2'b00; addr = {4'd12, 4'd8};
    first_addr = -1;
    begin
      logic [1:0] got = 2'b00;
      logic [7:0] r0 = '0, r1 = '0;
      for (int k = 0; k < 40 && got != 2'b11; k++) begin
        #1;
        if (bus_valid && first_addr < 0) first_addr = int'(bus_addr);
        @(negedge clk);
        if (done[0]) begin got[0] = 1'b1; r0 = rdata[7:0]; req[0] = 1'b0; end
        if (done[1]) begin got[1] = 1'b1; r1 = rdata[15:8]; req[1] = 1'b0; end
      end
      chk(first_addr == 8, "R9 lowest core first", first_addr, 8);
      chk(got == 2'b11, "R10 both complete", got, 3);
      chk(r0 == init_val(8) && r1 == init_val(12), "R9 values", {r1, r0}, {init_val(12), init_val(8)});
    end

    // R11: sweep ping-pong ownership across every address
    for (int a = 0; a < 16; a++) begin
      logic [7:0] v0, v1;
      v0 = 8'((a * 13 + 33) & 255);
      v1 = 8'((a * 29 + 71) & 255);
      op(0, 1, a, v0, rd, cyc);
      op(1, 0, a, 0, rd, cyc);
      chk(rd == model[a], "R11 core1 sees core0 write", rd, model[a]);
      op(1, 1, a, v1, rd, cyc);
      op(0, 0, a, 0, rd, cyc);
      chk(rd == model[a], "R11 core0 sees core1 write", rd, model[a]);
      chk(cyc <= 3, "R10 bounded stall", cyc, 3);
    end
    for (int a = 15; a >= 0; a--) begin
      for (int c = 0; c < 2; c++) begin
        op(c, 0, a, 0, rd, cyc);
        chk(rd == model[a], "R11 final agreement", rd, model[a]);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule